// File: doc/BRIEF.md
# Power-Mode Direct Transition Controller

This block sequences the operating modes of a small microcontroller. It starts in active high-speed mode. A one-cycle sleep request from the CPU is judged against five configuration bits held in registers: a standby select, a low-speed select, a medium-speed select, a direct-transition enable and a subclock-permit bit. From these bits the block picks the next mode. That mode is active high-speed, active medium-speed, subactive, sleep or standby. A request whose bit pattern has no defined meaning is refused and flagged.

A direct transition has three phases. First come three CPU states timed on the clock that was in use before the transition. Then the clock select switches. If the block is leaving subactive mode (or waking from standby), an oscillator stabilization wait follows, chosen by a 3-bit code and counted in states of the new clock. Last come fourteen exception-handling states on the new clock. A one-cycle wake-interrupt strobe marks the start of exception handling. The oscillator and the watch clock reach the block as enable pulses on a single fast clock. A per-state divider turns whichever source is selected into CPU state ticks.

Top module: `pmc_dt_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (active high-speed), clk_sel_o is 0, and busy_o, err_o and wake_irq_o are all 0.
- R2: In medium-speed mode (mode 1), a sleep request with cfg_standby=0, cfg_lowspd=0, cfg_medspd=0 and cfg_direct=1 ends in high-speed mode (mode 0). The transition spends 3 medium states and then 14 high-speed states. With med_div=0 this totals 76 oscillator pulses.
- R3: In subactive mode (mode 2), a sleep request with cfg_standby=1, cfg_lowspd=0, cfg_medspd=0, cfg_direct=1 and cfg_subclk=1 ends in high-speed mode. The transition spends 3 subactive states and then (wait + 14) high-speed states. With sub_div=2 and wait_sel=0 this is 24 watch pulses followed by 16412 oscillator pulses.
- R4: wait_sel selects the stabilization wait in states. Codes 0 to 4 give 8192, 16384, 32768, 65536 and 131072 states. Codes 5, 6 and 7 give 2, 8 and 16 states. The code is captured when the request is accepted, and later changes to wait_sel have no effect.
- R5: In high-speed mode, a sleep request with cfg_standby=0, cfg_lowspd=0, cfg_medspd=1 and cfg_direct=1 ends in medium-speed mode. The transition spends 3 high-speed states and then 14 medium states, with no wait.
- R6: In high-speed or medium-speed mode, a request with cfg_standby=1, cfg_lowspd=1, cfg_direct=1 and cfg_subclk=1 ends in subactive mode. The transition spends 3 states of the old clock and then 14 subactive states, with no wait.
- R7: In an active fast mode, a request with cfg_direct=0, cfg_standby=0 and cfg_lowspd=0 enters sleep (mode 3) after 3 states and drops busy_o. In sleep the clock select is kept. A wake_req pulse returns the block to the prior mode, with 14 states of that mode's clock. wake_req outside sleep and standby has no effect.
- R8: In an active fast mode, a request with cfg_direct=0, cfg_standby=1 and cfg_lowspd=0 enters standby (mode 4) after 3 states, with clk_sel_o=3. A wake_req pulse moves the block to high-speed mode, with (wait + 14) high-speed states.
- R9: Any other bit pattern, or any request in subactive mode that does not match R3, raises err_o for exactly one cycle. In that case mode_o stays unchanged and busy_o stays 0.
- R10: busy_o is 1 from the cycle after an accepted request or wake until the edge of the last exception state. Sleep requests made while busy_o is 1, or while in sleep or standby, are ignored.
- R11: wake_irq_o pulses for one cycle at the start of exception handling. That is right after the clock switch when there is no wait, or right after the last wait state.
- R12: clk_sel_o is 0 for high-speed (2 oscillator pulses per state). It is 1 for medium-speed (16 << med_div oscillator pulses per state). It is 2 for subactive (2 << sub_div watch pulses per state, with sub_div=3 giving 8). It is 3 for stopped. The code changes on the edge of the third pre-transition state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator period enable |
| wat_en | input | 1 | Watch clock period enable |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| wake_req | input | 1 | Wake event for sleep or standby |
| cfg_standby | input | 1 | Standby select bit |
| cfg_lowspd | input | 1 | Low-speed (subclock) select bit |
| cfg_medspd | input | 1 | Medium-speed select bit |
| cfg_direct | input | 1 | Direct-transition enable bit |
| cfg_subclk | input | 1 | Subclock-permit bit |
| wait_sel | input | 3 | Stabilization wait code |
| med_div | input | 2 | Medium-speed divider select |
| sub_div | input | 2 | Subactive divider select |
| mode_o | output | 3 | Current mode: 0 high, 1 medium, 2 subactive, 3 sleep, 4 standby |
| clk_sel_o | output | 2 | Clock-select code |
| busy_o | output | 1 | Transition in progress |
| err_o | output | 1 | One-cycle invalid-request flag |
| wake_irq_o | output | 1 | One-cycle wake-interrupt strobe |

## Verification
The bench counts source pulses on each side of the clock switch. A design that timed the three pre-transition states on the new clock, or that let its divider run free across the request, would miss the exact counts (76 pulses, or 24 watch plus 16412 oscillator pulses). The bench sweeps every medium divider and several subactive divider and wait-code pairings. A wrong shift in either divider would therefore show up as a count mismatch.

The bench also changes wait_sel while the block is in standby, so a design that did not capture the code at the request would stretch the wake. It places the strobe position against the wait length, so a strobe that fired at the switch would show. Further probes send sleep requests in the middle of a transition and while asleep, send invalid patterns in each active mode, and send wake pulses while active. A design that re-entered the sequence, changed mode on a refused request, or flagged an ignored one would be caught.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int WAIT_W = 18;

  typedef enum logic [2:0] {
    MD_HIGH  = 3'd0,
    MD_MED   = 3'd1,
    MD_SUB   = 3'd2,
    MD_SLEEP = 3'd3,
    MD_STBY  = 3'd4
  } pm_mode_e;

  typedef enum logic [1:0] {
    SEL_OSC2 = 2'd0,
    SEL_MED  = 2'd1,
    SEL_SUB  = 2'd2,
    SEL_OFF  = 2'd3
  } pm_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_PRE  = 3'd1,
    SQ_WAIT = 3'd2,
    SQ_EXC  = 3'd3,
    SQ_HALT = 3'd4
  } pm_seq_e;

  // Stabilization wait length in states for each code.
  function automatic logic [WAIT_W-1:0] wait_states(input logic [2:0] code);
    logic [WAIT_W-1:0] n;
    case (code)
      3'd5:    n = WAIT_W'(2);
      3'd6:    n = WAIT_W'(8);
      3'd7:    n = WAIT_W'(16);
      default: n = WAIT_W'(32'd8192 << code);
    endcase
    return n;
  endfunction

  function automatic pm_sel_e sel_of(input pm_mode_e m);
    pm_sel_e s;
    case (m)
      MD_MED:  s = SEL_MED;
      MD_SUB:  s = SEL_SUB;
      MD_STBY: s = SEL_OFF;
      default: s = SEL_OSC2;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  pm_mode_e cur_mode,
  input  logic     cfg_standby,
  input  logic     cfg_lowspd,
  input  logic     cfg_medspd,
  input  logic     cfg_direct,
  input  logic     cfg_subclk,
  output logic     dec_valid,
  output pm_mode_e dec_tgt,
  output logic     dec_wait
);

  logic fast_mode;
  assign fast_mode = (cur_mode == MD_HIGH) || (cur_mode == MD_MED);

  always_comb begin
    dec_valid = 1'b0;
    dec_tgt   = cur_mode;
    dec_wait  = 1'b0;
    if (fast_mode) begin
      if (!cfg_direct) begin
        if (!cfg_lowspd) begin
          dec_valid = 1'b1;
          dec_tgt   = cfg_standby ? MD_STBY : MD_SLEEP;
        end
      end else if (cfg_standby && cfg_lowspd && cfg_subclk) begin
        dec_valid = 1'b1;
        dec_tgt   = MD_SUB;
      end else if (!cfg_standby && !cfg_lowspd) begin
        if ((cur_mode == MD_HIGH) && cfg_medspd) begin
          dec_valid = 1'b1;
          dec_tgt   = MD_MED;
        end else if ((cur_mode == MD_MED) && !cfg_medspd) begin
          dec_valid = 1'b1;
          dec_tgt   = MD_HIGH;
        end
      end
    end else if (cur_mode == MD_SUB) begin
      if (cfg_direct && cfg_standby && !cfg_lowspd && !cfg_medspd && cfg_subclk) begin
        dec_valid = 1'b1;
        dec_tgt   = MD_HIGH;
        dec_wait  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pmc_state_tick.sv
module pmc_state_tick
  import pmc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wat_en,
  input  pm_sel_e    sel,
  input  logic [1:0] med_div,
  input  logic [1:0] sub_div,
  input  logic       restart,
  output logic       tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d, last;
  logic             src;

  always_comb begin
    case (sel)
      SEL_OSC2: begin
        src  = osc_en;
        last = DIV_W'(1);
      end
      SEL_MED: begin
        src  = osc_en;
        last = DIV_W'((32'd16 << med_div) - 32'd1);
      end
      SEL_SUB: begin
        src  = wat_en;
        last = sub_div[1] ? DIV_W'(7) : DIV_W'((32'd2 << sub_div) - 32'd1);
      end
      default: begin
        src  = 1'b0;
        last = '0;
      end
    endcase
  end

  assign tick = src && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (src)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pmc_seq_ctrl.sv
module pmc_seq_ctrl
  import pmc_pkg::*;
#(
  parameter int PRE_STATES = 3,
  parameter int EXC_STATES = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       tick,
  input  logic       dec_valid,
  input  pm_mode_e   dec_tgt,
  input  logic       dec_wait,
  input  logic [2:0] wait_sel,
  output pm_mode_e   mode,
  output pm_sel_e    sel,
  output logic       busy,
  output logic       err,
  output logic       irq,
  output logic       restart
);

  pm_seq_e           sq_q, sq_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  pm_mode_e          mode_q, mode_d, tgt_q, tgt_d, orig_q, orig_d;
  pm_sel_e           sel_q, sel_d;
  logic [2:0]        wsel_q, wsel_d;
  logic              wneed_q, wneed_d;
  logic              err_q, err_d, irq_q, irq_d;
  logic [WAIT_W-1:0] wait_last;

  assign wait_last = wait_states(wsel_q) - 1'b1;

  always_comb begin
    sq_d    = sq_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    tgt_d   = tgt_q;
    orig_d  = orig_q;
    sel_d   = sel_q;
    wsel_d  = wsel_q;
    wneed_d = wneed_q;
    err_d   = 1'b0;
    irq_d   = 1'b0;
    restart = 1'b0;
    case (sq_q)
      SQ_IDLE: begin
        if (sleep_req) begin
          if (dec_valid) begin
            sq_d    = SQ_PRE;
            cnt_d   = '0;
            tgt_d   = dec_tgt;
            wneed_d = dec_wait;
            wsel_d  = wait_sel;
            restart = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      SQ_PRE: begin
        if (tick) begin
          if (cnt_q == WAIT_W'(PRE_STATES - 1)) begin
            cnt_d   = '0;
            restart = 1'b1;
            mode_d  = tgt_q;
            if ((tgt_q == MD_SLEEP) || (tgt_q == MD_STBY)) begin
              orig_d = mode_q;
              sq_d   = SQ_HALT;
              if (tgt_q == MD_STBY) sel_d = SEL_OFF;
            end else begin
              sel_d = sel_of(tgt_q);
              if (wneed_q) begin
                sq_d = SQ_WAIT;
              end else begin
                sq_d  = SQ_EXC;
                irq_d = 1'b1;
              end
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SQ_WAIT: begin
        if (tick) begin
          if (cnt_q == wait_last) begin
            cnt_d = '0;
            sq_d  = SQ_EXC;
            irq_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SQ_EXC: begin
        if (tick) begin
          if (cnt_q == WAIT_W'(EXC_STATES - 1)) begin
            cnt_d = '0;
            sq_d  = SQ_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SQ_HALT: begin
        if (wake_req) begin
          restart = 1'b1;
          cnt_d   = '0;
          if (mode_q == MD_SLEEP) begin
            mode_d = orig_q;
            sel_d  = sel_of(orig_q);
            sq_d   = SQ_EXC;
            irq_d  = 1'b1;
          end else begin
            mode_d = MD_HIGH;
            sel_d  = SEL_OSC2;
            sq_d   = SQ_WAIT;
          end
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q    <= SQ_IDLE;
      cnt_q   <= '0;
      mode_q  <= MD_HIGH;
      tgt_q   <= MD_HIGH;
      orig_q  <= MD_HIGH;
      sel_q   <= SEL_OSC2;
      wsel_q  <= 3'd0;
      wneed_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sq_q    <= sq_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      tgt_q   <= tgt_d;
      orig_q  <= orig_d;
      sel_q   <= sel_d;
      wsel_q  <= wsel_d;
      wneed_q <= wneed_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
    end
  end

  assign mode = mode_q;
  assign sel  = sel_q;
  assign busy = (sq_q != SQ_IDLE) && (sq_q != SQ_HALT);
  assign err  = err_q;
  assign irq  = irq_q;

endmodule

// File: rtl/pmc_dt_ctrl.sv
module pmc_dt_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int PRE_STATES = 3,
  parameter int EXC_STATES = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wat_en,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       cfg_standby,
  input  logic       cfg_lowspd,
  input  logic       cfg_medspd,
  input  logic       cfg_direct,
  input  logic       cfg_subclk,
  input  logic [2:0] wait_sel,
  input  logic [1:0] med_div,
  input  logic [1:0] sub_div,
  output logic [2:0] mode_o,
  output logic [1:0] clk_sel_o,
  output logic       busy_o,
  output logic       err_o,
  output logic       wake_irq_o
);

  logic     rst_meta, rst_sync_n;
  pm_mode_e cur_mode, dec_tgt;
  pm_sel_e  cur_sel;
  logic     dec_valid, dec_wait, tick, restart;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pmc_mode_decode u_dec (
    .cur_mode    (cur_mode),
    .cfg_standby (cfg_standby),
    .cfg_lowspd  (cfg_lowspd),
    .cfg_medspd  (cfg_medspd),
    .cfg_direct  (cfg_direct),
    .cfg_subclk  (cfg_subclk),
    .dec_valid   (dec_valid),
    .dec_tgt     (dec_tgt),
    .dec_wait    (dec_wait)
  );

  pmc_state_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .osc_en  (osc_en),
    .wat_en  (wat_en),
    .sel     (cur_sel),
    .med_div (med_div),
    .sub_div (sub_div),
    .restart (restart),
    .tick    (tick)
  );

  pmc_seq_ctrl #(.PRE_STATES(PRE_STATES), .EXC_STATES(EXC_STATES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .tick      (tick),
    .dec_valid (dec_valid),
    .dec_tgt   (dec_tgt),
    .dec_wait  (dec_wait),
    .wait_sel  (wait_sel),
    .mode      (cur_mode),
    .sel       (cur_sel),
    .busy      (busy_o),
    .err       (err_o),
    .irq       (wake_irq_o),
    .restart   (restart)
  );

  assign mode_o    = cur_mode;
  assign clk_sel_o = cur_sel;

endmodule

// File: rtl/pmc_dt_ctrl_chk.sv
module pmc_dt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       wake_req,
  input logic [2:0] mode_o,
  input logic [1:0] clk_sel_o,
  input logic       busy_o,
  input logic       err_o,
  input logic       wake_irq_o
);

  p_err_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (mode_o == $past(mode_o)));

  p_err_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(sleep_req));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(sleep_req) || $past(wake_req)));

  p_mode_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> ($past(busy_o) || $past(wake_req)));

  p_irq_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o |-> busy_o);

  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o |=> !wake_irq_o);

  p_standby_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |-> (clk_sel_o == 2'd3));

  p_idle_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && mode_o <= 3'd2) |-> (clk_sel_o == mode_o[1:0]));

endmodule

bind pmc_dt_ctrl pmc_dt_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_req  (sleep_req),
  .wake_req   (wake_req),
  .mode_o     (mode_o),
  .clk_sel_o  (clk_sel_o),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .wake_irq_o (wake_irq_o)
);

// File: tb/pmc_dt_ctrl_tb.sv
`timescale 1ns/1ps
module pmc_dt_ctrl_tb_top;

  logic       clk, rst_n, osc_en, wat_en, sleep_req, wake_req;
  logic       cfg_standby, cfg_lowspd, cfg_medspd, cfg_direct, cfg_subclk;
  logic [2:0] wait_sel;
  logic [1:0] med_div, sub_div;
  logic [2:0] mode_o;
  logic [1:0] clk_sel_o;
  logic       busy_o, err_o, wake_irq_o;

  int n_chk = 0, n_err = 0;
  int r_pre, r_post, r_irqs, r_irq_at, r_errs;
  int cyc = 0;
  bit done = 0;

  pmc_dt_ctrl dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Source enables: oscillator 2 of every 3 cycles, watch every 5th cycle.
  always @(negedge clk) begin
    cyc    <= cyc + 1;
    osc_en <= ((cyc % 3) != 2);
    wat_en <= ((cyc % 5) == 0);
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int per_state(input int sel, input int md, input int sd);
    if (sel == 0) return 2;
    if (sel == 1) return 16 << md;
    return (sd >= 2) ? 8 : (2 << sd);
  endfunction

  function automatic int wlen(input int c);
    if (c < 5) return 8192 << c;
    if (c == 5) return 2;
    if (c == 6) return 8;
    return 16;
  endfunction

  task automatic set_cfg(input bit sb, input bit ls, input bit ms, input bit dt, input bit sc);
    cfg_standby = sb; cfg_lowspd = ls; cfg_medspd = ms; cfg_direct = dt; cfg_subclk = sc;
  endtask

  // Issue a request (or wake), then count source pulses before and after the clock switch.
  task automatic run(input bit is_wake, input int inj);
    int  start_sel;
    int  sel_b;
    bit  in_pre;
    r_pre = 0; r_post = 0; r_irqs = 0; r_irq_at = -1; r_errs = 0;
    @(negedge clk);
    if (is_wake) wake_req = 1'b1; else sleep_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sleep_req = 1'b0; wake_req = 1'b0;
    start_sel = int'(clk_sel_o);
    in_pre = !is_wake;
    for (int k = 0; k < 300000; k++) begin
      sleep_req = 1'b0;
      if (wake_irq_o) begin r_irqs++; r_irq_at = r_post; end
      if (err_o) r_errs++;
      if (in_pre && int'(clk_sel_o) != start_sel) in_pre = 0;
      if (!busy_o) break;
      sel_b = int'(clk_sel_o);
      if (k == inj) sleep_req = 1'b1;
      @(posedge clk);
      if (in_pre) r_pre += (sel_b == 2) ? int'(wat_en) : int'(osc_en);
      else        r_post += (sel_b == 2) ? int'(wat_en) : int'(osc_en);
      @(negedge clk);
    end
    sleep_req = 1'b0;
  endtask

  task automatic check_trans(input string rq, input int em, input int es, input int ep,
                             input int eq, input int eirq);
    chk({rq, " pre pulses"}, r_pre, ep);
    chk({rq, " post pulses"}, r_post, eq);
    chk({rq, " strobe count"}, r_irqs, (eirq >= 0) ? 1 : 0);
    if (eirq >= 0) chk({rq, " strobe position (R11)"}, r_irq_at, eirq);
    chk({rq, " no error (R10)"}, r_errs, 0);
    chk({rq, " mode"}, int'(mode_o), em);
    chk({rq, " clock select (R12)"}, int'(clk_sel_o), es);
    chk({rq, " busy low"}, int'(busy_o), 0);
  endtask

  task automatic bad_req(input string rq);
    int m0;
    @(negedge clk);
    m0 = int'(mode_o);
    sleep_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sleep_req = 1'b0;
    chk({rq, " err raised"}, int'(err_o), 1);
    chk({rq, " busy stays low"}, int'(busy_o), 0);
    @(negedge clk);
    chk({rq, " err one cycle"}, int'(err_o), 0);
    chk({rq, " mode kept"}, int'(mode_o), m0);
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    osc_en = 1'b0; wat_en = 1'b0;
    set_cfg(0, 0, 0, 0, 0);
    wait_sel = 3'd0; med_div = 2'd0; sub_div = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 mode", int'(mode_o), 0);
    chk("R1 clk_sel", int'(clk_sel_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 strobe", int'(wake_irq_o), 0);

    set_cfg(0, 0, 0, 1, 0); bad_req("R9 high to high");
    set_cfg(0, 1, 0, 0, 0); bad_req("R9 low-speed without direct");

    for (int md = 0; md < 4; md++) begin
      med_div = 2'(md);
      set_cfg(0, 0, 1, 1, 0);
      run(0, (md == 1) ? 3 : -1);
      check_trans("R5 high to medium", 1, 1, 6, 14 * (16 << md), 0);
      if (md == 0) begin
        set_cfg(0, 0, 1, 1, 0); bad_req("R9 medium to medium");
      end
      set_cfg(0, 0, 0, 1, 0);
      run(0, (md == 2) ? 10 : -1);
      check_trans("R2 medium to high", 0, 0, 3 * (16 << md), 28, 0);
      if (md == 0) chk("R2 total 76 pulses", r_pre + r_post, 76);
    end

    // Medium to subactive, then subactive exits.
    med_div = 2'd0; sub_div = 2'd1;
    set_cfg(0, 0, 1, 1, 0); run(0, -1);
    set_cfg(1, 1, 0, 1, 1); run(0, -1);
    check_trans("R6 medium to subactive", 2, 2, 48, 14 * 4, 0);
    set_cfg(1, 0, 0, 1, 0); bad_req("R9 subactive without permit");
    wait_sel = 3'd6;
    set_cfg(1, 0, 0, 1, 1); run(0, 5);
    check_trans("R3 R4 subactive to high code 6", 0, 0, 12, (8 + 14) * 2, 16);

    for (int t = 0; t < 4; t++) begin
      int sd, sc;
      sd = (t == 0) ? 0 : (t == 1) ? 2 : (t == 2) ? 3 : 2;
      sc = (t == 0) ? 5 : (t == 1) ? 7 : (t == 2) ? 5 : 0;
      sub_div = 2'(sd);
      set_cfg(1, 1, 0, 1, 1); run(0, -1);
      check_trans("R6 high to subactive", 2, 2, 6, 14 * per_state(2, 0, sd), 0);
      wait_sel = 3'(sc);
      set_cfg(1, 0, 0, 1, 1); run(0, -1);
      check_trans("R3 R4 subactive to high", 0, 0, 3 * per_state(2, 0, sd),
                  (wlen(sc) + 14) * 2, wlen(sc) * 2);
    end

    // Sleep from medium with med_div=1.
    med_div = 2'd1;
    set_cfg(0, 0, 1, 1, 0); run(0, -1);
    set_cfg(0, 0, 1, 0, 0); run(0, -1);
    check_trans("R7 enter sleep", 3, 1, 3 * 32, 0, -1);
    set_cfg(0, 0, 0, 1, 0);
    @(negedge clk); sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    @(negedge clk);
    chk("R10 request in sleep ignored mode", int'(mode_o), 3);
    chk("R10 request in sleep no error", int'(err_o), 0);
    chk("R10 request in sleep busy", int'(busy_o), 0);
    run(1, -1);
    check_trans("R7 wake from sleep", 1, 1, 0, 14 * 32, 0);
    @(negedge clk); wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    @(negedge clk);
    chk("R7 wake while active busy", int'(busy_o), 0);
    chk("R7 wake while active mode", int'(mode_o), 1);
    set_cfg(0, 0, 0, 1, 0); run(0, -1);
    check_trans("R2 medium to high div 1", 0, 0, 96, 28, 0);

    // Standby with code 7 captured, then changed before wake.
    wait_sel = 3'd7;
    set_cfg(1, 0, 0, 0, 0); run(0, -1);
    check_trans("R8 enter standby", 4, 3, 6, 0, -1);
    wait_sel = 3'd0;
    run(1, -1);
    check_trans("R8 R4 wake from standby", 0, 0, 0, (16 + 14) * 2, 32);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule